// File: doc/BRIEF.md
# MSI Receive and Pending-Flag Unit

This unit catches message-signalled interrupts carried by inbound posted memory writes. Software programs a 64-bit target address into two 32-bit registers, and bit 0 of the low word turns capture on. When an enabled, matching inbound write arrives, the low five bits of its data pick one of 32 pending flags, and that flag is set.

Software reads the flag register, clears the lowest set flag by writing a one to that bit, and reads again until the register is zero. A flag that arrives in the same cycle as a clear is kept. A per-vector enable register decides which flags drive the interrupt output. A legacy level interrupt input is ORed onto the same line. The output is registered.

Top module: `msi_capture`

## Requirements
- R1: After reset, all four registers read zero and `irq_out` is low.
- R2: Register select 0 holds the low target word and select 1 the high word. Both read back exactly as written, bit 0 of the low word included. Bit 0 of the low word is the capture enable.
- R3: An inbound write sets pending flag `in_data[4:0]` when capture is enabled, its address bits 63:2 equal `{high word, low word[31:2]}`, and its data is below 32. The flag reads back (select 2) in the cycle after the write.
- R4: Address bits 1:0 of an inbound write do not affect matching. A write with a different address in bits 63:2, or a write that arrives while capture is disabled, leaves the flags unchanged.
- R5: Inbound data of 32 or above sets no flag.
- R6: A register write to select 2 clears each flag whose data bit is 1 and leaves every other flag unchanged.
- R7: If an inbound write sets a flag in the same cycle that a register write clears it, the flag ends up set.
- R8: Select 3 is the per-vector enable. `irq_out` is high one cycle after any flag is set while its enable bit is also set, and low one cycle after no enabled flag remains.
- R9: The legacy input `intx_in` is ORed into `irq_out` with the same one-cycle delay, and it never appears in the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 low target, 1 high target, 2 flags, 3 enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_sel` |
| in_valid | input | 1 | Inbound write valid |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (vector number) |
| intx_in | input | 1 | Legacy interrupt level sharing the output |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
Register writes and flag changes are visible on `reg_rdata` one edge after the write is presented, and `irq_out` follows one edge later still. The driver applies each stimulus just after a rising edge and waits the stated number of edges. It then queues the expected value, and the monitor compares it at the next falling edge. The checks include a reading of `irq_out` taken directly after a flag sets, while the output must still be low, so that a missing output register is caught.

// File: rtl/msi_capture.sv
module msi_capture #(
  parameter int NVEC = 32,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wen,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          in_valid,
  input  logic [2*DW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          intx_in,
  output logic          irq_out
);
  localparam int AW = 2 * DW;
  localparam int VW = $clog2(NVEC);
  localparam logic [1:0] SEL_LO  = 2'd0;
  localparam logic [1:0] SEL_HI  = 2'd1;
  localparam logic [1:0] SEL_PND = 2'd2;
  localparam logic [1:0] SEL_EN  = 2'd3;

  logic [DW-1:0]   tgt_lo, tgt_hi;
  logic [NVEC-1:0] pend, vec_en;
  logic [NVEC-1:0] set_mask, clr_mask;
  logic            hit, in_range;

  assign hit      = in_valid && tgt_lo[0] && (in_addr[AW-1:2] == {tgt_hi, tgt_lo[DW-1:2]});
  assign in_range = in_data < DW'(NVEC);
  assign set_mask = (hit && in_range) ? (NVEC'(1) << in_data[VW-1:0]) : '0;
  assign clr_mask = (reg_wen && reg_sel == SEL_PND) ? reg_wdata[NVEC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_lo  <= '0;
      tgt_hi  <= '0;
      vec_en  <= '0;
      pend    <= '0;
      irq_out <= 1'b0;
    end else begin
      if (reg_wen && reg_sel == SEL_LO) tgt_lo <= reg_wdata;
      if (reg_wen && reg_sel == SEL_HI) tgt_hi <= reg_wdata;
      if (reg_wen && reg_sel == SEL_EN) vec_en <= reg_wdata[NVEC-1:0];
      pend    <= (pend & ~clr_mask) | set_mask;
      irq_out <= (|(pend & vec_en)) | intx_in;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_LO:  reg_rdata = tgt_lo;
      SEL_HI:  reg_rdata = tgt_hi;
      SEL_PND: reg_rdata[NVEC-1:0] = pend;
      default: reg_rdata[NVEC-1:0] = vec_en;
    endcase
  end
endmodule

module msi_capture_chk #(
  parameter int NVEC = 32,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wen,
  input logic [1:0]      reg_sel,
  input logic [DW-1:0]   reg_wdata,
  input logic            in_valid,
  input logic [2*DW-1:0] in_addr,
  input logic [DW-1:0]   in_data,
  input logic            intx_in,
  input logic            irq_out,
  input logic [DW-1:0]   tgt_lo,
  input logic [DW-1:0]   tgt_hi,
  input logic [NVEC-1:0] pend,
  input logic [NVEC-1:0] vec_en
);
  localparam int VW = $clog2(NVEC);

  // R3 R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tgt_lo[0] && in_addr[2*DW-1:2] == {tgt_hi, tgt_lo[DW-1:2]} && in_data < DW'(NVEC))
    |=> pend[$past(in_data[VW-1:0])]);

  // R4 R5
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !(reg_wen && reg_sel == 2'd2)) |=> $stable(pend));

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_sel == 2'd2 && !in_valid) |=> ((pend & $past(reg_wdata[NVEC-1:0])) == '0));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & vec_en) != '0) |=> irq_out);

  // R8 R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend & vec_en) == '0) && !intx_in) |=> !irq_out);

  // R9
  intx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_in |=> irq_out);
endmodule

bind msi_capture msi_capture_chk #(.NVEC(NVEC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .in_valid(in_valid), .in_addr(in_addr),
  .in_data(in_data), .intx_in(intx_in), .irq_out(irq_out),
  .tgt_lo(tgt_lo), .tgt_hi(tgt_hi), .pend(pend), .vec_en(vec_en)
);

// File: tb/msi_capture_test.sv
`timescale 1ns/1ps
module msi_capture_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wen = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic intx_in = 1'b0;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  bit          irq_q[$];
  string       tag_q[$];
  logic        probe = 1'b0;

  always #2.5 clk = ~clk;

  msi_capture uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_addr(in_addr), .in_data(in_data), .intx_in(intx_in), .irq_out(irq_out)
  );

  always @(negedge clk) begin
    if (probe && exp_q.size() > 0) begin
      logic [31:0] e;
      logic [31:0] a;
      bit k;
      string t;
      e = exp_q.pop_front();
      k = irq_q.pop_front();
      t = tag_q.pop_front();
      a = k ? {31'd0, irq_out} : reg_rdata;
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_reg(input logic [1:0] sel, input logic [31:0] e, input string t);
    reg_sel = sel;
    exp_q.push_back(e); irq_q.push_back(1'b0); tag_q.push_back(t);
    probe = 1'b1;
    tick();
    probe = 1'b0;
  endtask

  task automatic expect_irq(input bit e, input string t);
    exp_q.push_back({31'd0, e}); irq_q.push_back(1'b1); tag_q.push_back(t);
    probe = 1'b1;
    tick();
    probe = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_wen = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wen = 1'b0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    in_valid = 1'b1; in_addr = a; in_data = d;
    tick();
    in_valid = 1'b0;
  endtask

  localparam logic [63:0] TGT = 64'h0000_0001_1000_0040;

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    expect_reg(2'd0, 32'h0, "R1 low target");
    expect_reg(2'd1, 32'h0, "R1 high target");
    expect_reg(2'd2, 32'h0, "R1 flags");
    expect_reg(2'd3, 32'h0, "R1 enables");
    expect_irq(1'b0, "R1 irq");

    // R4: capture disabled, address programmed, no flag
    wr(2'd0, 32'h1000_0040);
    wr(2'd1, 32'h0000_0001);
    msi(TGT, 32'd4);
    expect_reg(2'd2, 32'h0, "R4 disabled capture");

    // R2 readback with enable bit
    wr(2'd0, 32'h1000_0041);
    expect_reg(2'd0, 32'h1000_0041, "R2 low target readback");
    expect_reg(2'd1, 32'h0000_0001, "R2 high target readback");
    wr(2'd3, 32'hFFFF_FFFF);
    expect_reg(2'd3, 32'hFFFF_FFFF, "R8 enable readback");

    // R3 capture, flag visible next cycle; irq one cycle later (R8)
    msi(TGT, 32'd5);
    reg_sel = 2'd2;
    expect_irq(1'b0, "R8 irq not yet");
    expect_irq(1'b1, "R8 irq raised");
    expect_reg(2'd2, 32'h0000_0020, "R3 vector 5 set");

    // R4 low bits ignored
    msi(TGT | 64'h2, 32'd31);
    expect_reg(2'd2, 32'h8000_0020, "R4 addr bits 1:0 ignored");
    // R4 mismatches
    msi(TGT ^ 64'h4, 32'd7);
    msi(TGT ^ 64'h0000_0002_0000_0000, 32'd8);
    expect_reg(2'd2, 32'h8000_0020, "R4 mismatched address");
    // R5 out of range
    msi(TGT, 32'd32);
    msi(TGT, 32'h105);
    expect_reg(2'd2, 32'h8000_0020, "R5 data above 31");

    // R6 W1C
    wr(2'd2, 32'h0000_0020);
    expect_reg(2'd2, 32'h8000_0000, "R6 clear one flag");
    wr(2'd2, 32'h0000_0000);
    expect_reg(2'd2, 32'h8000_0000, "R6 zero write no effect");

    // R7 set wins, and another set during a clear is kept
    reg_wen = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h8000_0000;
    in_valid = 1'b1; in_addr = TGT; in_data = 32'd31;
    tick();
    reg_wen = 1'b0; in_valid = 1'b0;
    expect_reg(2'd2, 32'h8000_0000, "R7 set beats clear");
    reg_wen = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h8000_0000;
    in_valid = 1'b1; in_addr = TGT; in_data = 32'd3;
    tick();
    reg_wen = 1'b0; in_valid = 1'b0;
    expect_reg(2'd2, 32'h0000_0008, "R7 arrival during clear kept");

    // R8 gating
    wr(2'd3, 32'h0000_0001);
    tick();
    expect_irq(1'b0, "R8 masked flag");
    wr(2'd3, 32'h0000_0008);
    tick();
    expect_irq(1'b1, "R8 unmasked flag");
    wr(2'd2, 32'h0000_0008);
    expect_reg(2'd2, 32'h0, "R6 flags read zero");
    expect_irq(1'b0, "R8 irq drops");

    // R9 legacy sharing
    intx_in = 1'b1;
    tick();
    expect_irq(1'b1, "R9 intx drives irq");
    expect_reg(2'd2, 32'h0, "R9 intx not in flags");
    intx_in = 1'b0;
    tick();
    expect_irq(1'b0, "R9 intx released");

    repeat (2) tick();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule